// File: doc/BRIEF.md
# Ping-Pong Frame Buffer Arbiter

The arbiter sits between an incoming pixel stream and a back-end reader such as a DMA engine. It owns two frame memories of equal size. While one memory takes the frame that is arriving, the other is read out. Two ownership tokens make this safe. The write lock marks the memory that may be written and the read lock marks the memory that may be read. A memory never holds both tokens, and each token belongs to at most one memory.

Nothing happens while acquisition is disabled. In that state memory A holds the write lock and memory B holds the read lock. The first frame start seen with acquisition enabled opens an active period. In that period incoming pixels are written to the write-lock memory at addresses 0, 1, 2 and so on. In the same period the back end reads the other memory whenever it is ready. Once the configured number of pixels has been written, both locks are dropped for one cycle. They are then handed out again with the memories swapped, and the arbiter waits for the next frame start.

A back end that has not drained its memory by the next frame start does not stall the stream. The swap goes ahead and a one-cycle overrun flag is raised. Each memory is a synchronous RAM whose read word appears one clock after the read is issued.

Top module: `pingpong_frame_arbiter`

## Requirements
- R1: After reset, and in the idle state, wlock_a=1, rlock_b=1, wlock_b=0 and rlock_a=0. In that state no write-enable or output-enable is asserted.
- R2: At every cycle at most one of wlock_a/wlock_b is 1 and at most one of rlock_a/rlock_b is 1. No memory has both its write lock and its read lock set.
- R3: Write-enable and output-enable are only asserted in the active period. A memory is written only while it holds the write lock, and only in a cycle with wr_valid=1. The write address equals the number of pixels already written in this frame, starting at 0.
- R4: Suppose frame_len pixels have been written when a clock edge occurs. For the next cycle all four lock outputs are 0. From the cycle after that, the write lock and the read lock have swapped memories.
- R5: On the first frame start with acq_en=1, memory A is written and memory B is read. On each later accepted frame start the roles follow the swapped locks, so the memories alternate every frame.
- R6: In the active period the read-lock memory gets output-enable in every cycle with rd_ready=1, until frame_len words have been read. The read address counts from 0. No reads are issued outside the active period.
- R7: rd_valid is 1 exactly one cycle after an output-enable. rd_data then holds the word stored at that address during the previous frame.
- R8: A frame start can be accepted after the wait state while fewer than frame_len words were read in the previous active period. In that case overrun is 1 for exactly one cycle, the cycle after the start. Otherwise overrun stays 0.
- R9: frame_start has no effect during the active period, during the release cycle, or in the idle state with acq_en=0.
- R10: If acq_en is 0 during the wait state, the arbiter returns to idle with memory A again holding the write lock. The next frame start then writes memory A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acq_en | input | 1 | Acquisition enable |
| frame_start | input | 1 | One-cycle frame start pulse |
| frame_len | input | ADDR_W+1 | Pixels per frame, 1 to 2**ADDR_W |
| wr_valid | input | 1 | Incoming pixel valid |
| wr_data | input | DATA_W | Incoming pixel value |
| rd_ready | input | 1 | Back end can accept a word |
| we_a | output | 1 | Write-enable, memory A |
| we_b | output | 1 | Write-enable, memory B |
| oe_a | output | 1 | Output-enable, memory A |
| oe_b | output | 1 | Output-enable, memory B |
| addr_a | output | ADDR_W | Address, memory A |
| addr_b | output | ADDR_W | Address, memory B |
| wlock_a | output | 1 | Memory A holds the write lock |
| wlock_b | output | 1 | Memory B holds the write lock |
| rlock_a | output | 1 | Memory A holds the read lock |
| rlock_b | output | 1 | Memory B holds the read lock |
| rd_data | output | DATA_W | Word read from the read-lock memory |
| rd_valid | output | 1 | rd_data is valid |
| overrun | output | 1 | Readout incomplete at the frame swap |

## Verification
Enables, addresses and lock outputs are combinational from the state and the present inputs, so they are due in the same cycle as the stimulus. rd_data, rd_valid and overrun pass through one register and are due one cycle after the read or frame start that causes them. The release of the locks is due one cycle after the final pixel, and the swapped grant one cycle after that. The bench drives inputs at the falling edge and compares every output a little later in that same half-cycle. Its expected values come from a behavioural model that it advances at each rising edge, so each registered result is compared exactly one cycle after its cause.

// File: rtl/ppfa_pkg.sv
package ppfa_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_ACTIVE  = 2'd1,
    ST_RELEASE = 2'd2,
    ST_WAIT    = 2'd3
  } arb_state_t;

  localparam int unsigned NUM_BANKS = 2;
endpackage

// File: rtl/ppfa_count.sv
module ppfa_count #(
  parameter int unsigned W = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)     cnt_d = '0;
    else if (en) cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (clr | en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/ppfa_bank_ram.sv
module ppfa_bank_ram #(
  parameter int unsigned AW = 12,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic          oe,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (oe) rdata_q <= mem[addr];
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/ppfa_lock_fsm.sv
module ppfa_lock_fsm
  import ppfa_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acq_en,
  input  logic       frame_start,
  input  logic       frame_end,
  input  logic       rd_done,
  output arb_state_t state,
  output logic       wsel,
  output logic       start_go,
  output logic       overrun
);
  arb_state_t st_q, st_d;
  logic       wsel_q, wsel_d;
  logic       ovr_q, ovr_d;

  always_comb begin
    st_d     = st_q;
    wsel_d   = wsel_q;
    ovr_d    = 1'b0;
    start_go = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        wsel_d = 1'b0;
        if (acq_en && frame_start) begin
          st_d     = ST_ACTIVE;
          start_go = 1'b1;
        end
      end
      ST_ACTIVE: begin
        if (frame_end) st_d = ST_RELEASE;
      end
      ST_RELEASE: begin
        st_d   = ST_WAIT;
        wsel_d = ~wsel_q;
      end
      ST_WAIT: begin
        if (!acq_en) begin
          st_d   = ST_IDLE;
          wsel_d = 1'b0;
        end else if (frame_start) begin
          st_d     = ST_ACTIVE;
          start_go = 1'b1;
          ovr_d    = ~rd_done;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      wsel_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      wsel_q <= wsel_d;
      ovr_q  <= ovr_d;
    end
  end

  assign state   = st_q;
  assign wsel    = wsel_q;
  assign overrun = ovr_q;

  assert_swap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RELEASE) |=> (wsel_q != $past(wsel_q)));
  assert_idle_bank_a_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE) |-> (wsel_q == 1'b0));
  assert_overrun_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_q |=> !ovr_q);
  assert_wait_exit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_WAIT) && !acq_en) |=> (st_q == ST_IDLE));
endmodule

// File: rtl/pingpong_frame_arbiter.sv
module pingpong_frame_arbiter
  import ppfa_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acq_en,
  input  logic              frame_start,
  input  logic [ADDR_W:0]   frame_len,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_ready,
  output logic              we_a,
  output logic              we_b,
  output logic              oe_a,
  output logic              oe_b,
  output logic [ADDR_W-1:0] addr_a,
  output logic [ADDR_W-1:0] addr_b,
  output logic              wlock_a,
  output logic              wlock_b,
  output logic              rlock_a,
  output logic              rlock_b,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              overrun
);
  localparam int unsigned CNT_W = ADDR_W + 1;

  arb_state_t        state;
  logic              wsel, start_go;
  logic              active, held;
  logic              wr_fire, rd_fire, frame_end, rd_done;
  logic [CNT_W-1:0]  wr_cnt, rd_cnt;
  logic              we_v   [NUM_BANKS];
  logic              oe_v   [NUM_BANKS];
  logic              wl_v   [NUM_BANKS];
  logic              rl_v   [NUM_BANKS];
  logic [ADDR_W-1:0] addr_v [NUM_BANKS];
  logic [DATA_W-1:0] q_v    [NUM_BANKS];
  logic              rsel_q, rvalid_q;

  assign active    = (state == ST_ACTIVE);
  assign held      = (state != ST_RELEASE);
  assign wr_fire   = active & wr_valid;
  assign rd_done   = (rd_cnt == frame_len);
  assign rd_fire   = active & rd_ready & (rd_cnt < frame_len);
  assign frame_end = wr_fire & (wr_cnt == (frame_len - CNT_W'(1)));

  ppfa_lock_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .acq_en(acq_en), .frame_start(frame_start),
    .frame_end(frame_end), .rd_done(rd_done), .state(state), .wsel(wsel),
    .start_go(start_go), .overrun(overrun)
  );

  ppfa_count #(.W(CNT_W)) u_wr_cnt (
    .clk(clk), .rst_n(rst_n), .clr(start_go), .en(wr_fire), .cnt(wr_cnt)
  );

  ppfa_count #(.W(CNT_W)) u_rd_cnt (
    .clk(clk), .rst_n(rst_n), .clr(start_go), .en(rd_fire), .cnt(rd_cnt)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic is_wr;
    assign is_wr     = (wsel == b[0]);
    assign wl_v[b]   = held & is_wr;
    assign rl_v[b]   = held & ~is_wr;
    assign we_v[b]   = wr_fire & is_wr;
    assign oe_v[b]   = rd_fire & ~is_wr;
    assign addr_v[b] = is_wr ? wr_cnt[ADDR_W-1:0] : rd_cnt[ADDR_W-1:0];

    ppfa_bank_ram #(.AW(ADDR_W), .DW(DATA_W)) u_ram (
      .clk(clk), .we(we_v[b]), .oe(oe_v[b]), .addr(addr_v[b]),
      .wdata(wr_data), .rdata(q_v[b])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      rsel_q   <= 1'b0;
    end else begin
      rvalid_q <= rd_fire;
      if (rd_fire) rsel_q <= ~wsel;
    end
  end

  assign we_a     = we_v[0];
  assign we_b     = we_v[1];
  assign oe_a     = oe_v[0];
  assign oe_b     = oe_v[1];
  assign addr_a   = addr_v[0];
  assign addr_b   = addr_v[1];
  assign wlock_a  = wl_v[0];
  assign wlock_b  = wl_v[1];
  assign rlock_a  = rl_v[0];
  assign rlock_b  = rl_v[1];
  assign rd_valid = rvalid_q;
  assign rd_data  = rsel_q ? q_v[1] : q_v[0];

  assert_lock_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wlock_a, wlock_b}) && $onehot0({rlock_a, rlock_b})
    && !(wlock_a && rlock_a) && !(wlock_b && rlock_b));
  assert_we_needs_lock_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (we_a |-> wlock_a) and (we_b |-> wlock_b));
  assert_oe_needs_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_a |-> rlock_a) and (oe_b |-> rlock_b));
  assert_rd_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_a || oe_b) |=> rd_valid);
  assert_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> !(wlock_a || wlock_b || rlock_a || rlock_b));
endmodule

// File: tb/test_pingpong_frame_arbiter.sv
module test_pingpong_frame_arbiter;
  localparam int AW = 12;
  localparam int DW = 8;
  localparam int FLEN = 6;

  logic clk = 1'b0;
  logic rst_n;
  logic acq_en, frame_start, wr_valid, rd_ready;
  logic [AW:0]   frame_len;
  logic [DW-1:0] wr_data;
  logic we_a, we_b, oe_a, oe_b, wlock_a, wlock_b, rlock_a, rlock_b, rd_valid, overrun;
  logic [AW-1:0] addr_a, addr_b;
  logic [DW-1:0] rd_data;

  always #2.5 clk = ~clk;

  pingpong_frame_arbiter #(.ADDR_W(AW), .DATA_W(DW)) i_pingpong_frame_arbiter (
    .clk(clk), .rst_n(rst_n), .acq_en(acq_en), .frame_start(frame_start),
    .frame_len(frame_len), .wr_valid(wr_valid), .wr_data(wr_data), .rd_ready(rd_ready),
    .we_a(we_a), .we_b(we_b), .oe_a(oe_a), .oe_b(oe_b), .addr_a(addr_a), .addr_b(addr_b),
    .wlock_a(wlock_a), .wlock_b(wlock_b), .rlock_a(rlock_a), .rlock_b(rlock_b),
    .rd_data(rd_data), .rd_valid(rd_valid), .overrun(overrun)
  );

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;
  bit done    = 0;

  // behavioural model: phase 0 idle, 1 active, 2 release, 3 wait
  int m_ph, m_wb, m_wc, m_rc;
  bit m_rv, m_rk, m_ov;
  int m_rd;
  int  mem   [2][int];
  int  pixel = 1;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  task automatic step(bit acq, bit fs, bit wv, bit rr);
    bit held, we, oe;
    int wd;
    @(negedge clk);
    wd = pixel & 8'hff;
    acq_en = acq; frame_start = fs; wr_valid = wv; rd_ready = rr; wr_data = wd[DW-1:0];
    #1;
    held = (m_ph != 2);
    we   = (m_ph == 1) && wv;
    oe   = (m_ph == 1) && rr && (m_rc < FLEN);
    vectors++;
    chk("R2 wlock_a", 32'(wlock_a), 32'(held && m_wb == 0));
    chk("R4 wlock_b", 32'(wlock_b), 32'(held && m_wb == 1));
    chk("R4 rlock_a", 32'(rlock_a), 32'(held && m_wb == 1));
    chk("R2 rlock_b", 32'(rlock_b), 32'(held && m_wb == 0));
    chk("R3 we_a", 32'(we_a), 32'(we && m_wb == 0));
    chk("R5 we_b", 32'(we_b), 32'(we && m_wb == 1));
    chk("R6 oe_a", 32'(oe_a), 32'(oe && m_wb == 1));
    chk("R6 oe_b", 32'(oe_b), 32'(oe && m_wb == 0));
    if (we || oe) begin
      chk("R3 addr_a", 32'(addr_a), 32'((m_wb == 0 ? m_wc : m_rc) % 4096));
      chk("R5 addr_b", 32'(addr_b), 32'((m_wb == 1 ? m_wc : m_rc) % 4096));
    end
    chk("R7 rd_valid", 32'(rd_valid), 32'(m_rv));
    if (m_rv && m_rk) chk("R7 rd_data", 32'(rd_data), 32'(m_rd));
    chk("R8 overrun", 32'(overrun), 32'(m_ov));
    @(posedge clk);
    m_rv = oe;
    if (oe) begin
      m_rk = mem[1 - m_wb].exists(m_rc);
      m_rd = m_rk ? mem[1 - m_wb][m_rc] : 0;
    end
    m_ov = 0;
    if (we) begin mem[m_wb][m_wc] = wd; pixel++; end
    case (m_ph)
      0: if (acq && fs) begin m_ph = 1; m_wc = 0; m_rc = 0; end
      1: begin
        if (we && m_wc == FLEN - 1) m_ph = 2;
        if (we) m_wc++;
        if (oe) m_rc++;
      end
      2: begin m_ph = 3; m_wb = 1 - m_wb; end
      default: begin
        if (!acq) begin m_ph = 0; m_wb = 0; end
        else if (fs) begin m_ph = 1; m_ov = (m_rc != FLEN); m_wc = 0; m_rc = 0; end
      end
    endcase
    cycles++;
  endtask

  // run one active period; mode 0: ready always, 1: ready sparse
  task automatic run_frame(int mode);
    int k = 0;
    step(1, 1, 0, 0);
    while (m_ph == 1 && k < 100) begin
      // a frame start in mid-frame must be ignored (R9)
      step(1, (k == 2), (k % 3) != 1, mode == 0 ? 1'b1 : (k == 0));
      k++;
    end
    step(1, 1'b1, 0, 0); // start during release cycle: ignored (R9)
    step(1, 0, 0, 0);    // wait state, swapped locks (R4)
  endtask

  initial begin
    acq_en = 0; frame_start = 0; wr_valid = 0; rd_ready = 0; wr_data = '0;
    frame_len = (AW + 1)'(FLEN);
    m_ph = 0; m_wb = 0; m_wc = 0; m_rc = 0; m_rv = 0; m_rk = 0; m_ov = 0; m_rd = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    // R1 reset state, R9 frame_start ignored with acq_en low
    step(0, 0, 1, 1);
    step(0, 1, 1, 1);
    step(0, 1, 0, 1);
    // R5 first frame writes A, reads B; R6 reads of unwritten memory
    run_frame(0);
    // R5 second frame writes B, reads A with full readout (R7 data)
    run_frame(0);
    // third frame: sparse ready leaves readout incomplete
    run_frame(1);
    // fourth frame start: overrun expected (R8)
    run_frame(0);
    run_frame(0);
    // R10 drop acquisition in wait state, then restart on memory A
    step(0, 0, 0, 0);
    step(0, 1, 1, 1);
    step(1, 0, 1, 1);
    run_frame(0);
    run_frame(0);
    step(1, 0, 0, 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule